// File: doc/BRIEF.md
# Dual-Lane Complex Multiply-Accumulate Datapath

This block is the arithmetic heart of a vector unit for complex baseband samples. Every operand element is a complex number built from a 16-bit signed real part and a 16-bit signed imaginary part. Two element streams (port A and port B) each deliver two elements per clock. Two identical lanes, each holding a complex multiplier and a wide complex adder, are steered by a per-cycle operation code. The same lanes can run a two-wide dot-product style accumulation, a single radix-2 butterfly, or a two-wide magnitude evaluation that feeds a running maximum search.

The accumulating operation writes into a bank of four complex accumulators. Each accumulator is 40 bits wide per component, wraps on overflow, and keeps a sticky overflow flag. A clear input loads a fresh value on the first element of a new vector, so no idle cycle is spent zeroing. The butterfly result and the maximum search result are registered and held between updates.

The maximum search is a two-state machine. SRCH_EMPTY is the state after reset, where no element has been seen yet. SRCH_LIVE means that a running maximum is held. The first-load transition goes from SRCH_EMPTY to SRCH_LIVE on the first magnitude cycle and takes that cycle's winner unconditionally. The fold transition stays in SRCH_LIVE on a magnitude cycle and replaces the maximum only if the candidate is strictly larger. The restart transition stays in SRCH_LIVE on a magnitude cycle with clear asserted; it takes the candidate unconditionally and resets the element index to 0.

Top module: `cmac_dual_lane`

## Requirements
- R1: After reset, every accumulator and overflow flag reads zero, `bf_valid_o` is low, and `max_mag_o` and `max_idx_o` read zero.
- R2: With `in_valid_i` high and `mode_i`=0 (accumulate), lane k (k=0,1) adds the complex product A[k]·B[k] to accumulator (`acc_sel_i`+k) mod 4. Element k of a port sits at bits [16k+15:16k]. The product has real part ar·br−ai·bi and imaginary part ar·bi+ai·br. The new value is visible on `acc_re_o`/`acc_im_o` (accumulator i at bits [40i+39:40i]) after the next clock edge.
- R3: If `clear_i` is high in an accumulate cycle, each targeted accumulator is loaded with its lane's product instead of the sum, and its overflow flag is cleared in the same edge.
- R4: Accumulation wraps modulo 2^40 per component. The overflow flag of an accumulator (`acc_ovf_o` bit i) is set when either component's true sum leaves the signed 40-bit range. The flag then stays set until a clearing accumulate cycle targets that accumulator.
- R5: With `mode_i`=1 (butterfly), x=A[0], y=A[1] and w=B[0] are used. Per component, output 0 is floor((x·2^15 + y·w)/2^16) and output 1 is floor((x·2^15 − y·w)/2^16), each 18 bits wide at bits [18k+17:18k]. `bf_valid_o` is high for exactly the cycle after the butterfly cycle. The accumulators are not touched.
- R6: With `mode_i`=2 (magnitude), the magnitude of A[k] is |re|+|im|. Element k of a magnitude cycle has index base+k. The base starts at 0 after reset or a clear and grows by 2 with each magnitude cycle, modulo 256.
- R7: In a magnitude cycle, the maximum is replaced only by a strictly larger magnitude. Ties keep the earlier index, and within one cycle element 0 wins a tie.
- R8: The first magnitude cycle after reset, and any magnitude cycle with `clear_i` high, takes that cycle's winner as the new maximum whatever the old value was. A clear also restarts the index base at 0.
- R9: With `in_valid_i` low or `mode_i`=3, no accumulator, flag or search state changes, and `bf_valid_o` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operands and control are valid this cycle |
| mode_i | input | 2 | 0 accumulate, 1 butterfly, 2 magnitude, 3 no operation |
| acc_sel_i | input | 2 | Accumulator targeted by lane 0 |
| clear_i | input | 1 | First element of a vector: load instead of accumulate / restart search |
| a_re_i | input | 32 | Port A real parts, two elements |
| a_im_i | input | 32 | Port A imaginary parts, two elements |
| b_re_i | input | 32 | Port B real parts, two elements |
| b_im_i | input | 32 | Port B imaginary parts, two elements |
| acc_re_o | output | 160 | Real parts of the four accumulators |
| acc_im_o | output | 160 | Imaginary parts of the four accumulators |
| acc_ovf_o | output | 4 | Sticky overflow flag per accumulator |
| bf_valid_o | output | 1 | Butterfly result updated last edge |
| bf_re_o | output | 36 | Butterfly outputs, real parts |
| bf_im_o | output | 36 | Butterfly outputs, imaginary parts |
| max_mag_o | output | 17 | Running maximum magnitude |
| max_idx_o | output | 8 | Index of the element holding the maximum |

## Verification
A wrong lane target or a missed clear shows up on the accumulator outputs one edge after the faulty cycle. It also stays there, because the accumulators hold their value until they are overwritten. A wrong overflow rule can only be seen after hundreds of full-scale products, so a long saturating run drives one accumulator past the 40-bit range and then checks that the flag survives other operations. A wrong search-state step, such as a bad tie rule or a missed restart, changes `max_idx_o` on the edge after the magnitude cycle where a tie or clear occurs. Every register-visible output is compared against the reference model on every clock, so such faults are reported on the cycle they first become visible.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

    typedef enum logic [1:0] {
        OP_MAC  = 2'd0,
        OP_BFLY = 2'd1,
        OP_MAG  = 2'd2,
        OP_NOP  = 2'd3
    } cmac_op_e;

    typedef enum logic {
        SRCH_EMPTY = 1'b0,
        SRCH_LIVE  = 1'b1
    } srch_state_e;

endpackage

// File: rtl/cmac_lane.sv
module cmac_lane #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
)(
    input  logic signed [DATA_W-1:0] x_re_i,
    input  logic signed [DATA_W-1:0] x_im_i,
    input  logic signed [DATA_W-1:0] y_re_i,
    input  logic signed [DATA_W-1:0] y_im_i,
    input  logic signed [ACC_W-1:0]  add_re_i,
    input  logic signed [ACC_W-1:0]  add_im_i,
    input  logic                     sub_i,
    output logic signed [ACC_W-1:0]  sum_re_o,
    output logic signed [ACC_W-1:0]  sum_im_o,
    output logic                     ovf_re_o,
    output logic                     ovf_im_o
);
    localparam int PROD_W = 2 * DATA_W + 1;
    localparam int EXT_W  = PROD_W - DATA_W;
    localparam int PAD_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] xr, xi, yr, yi;
    logic signed [PROD_W-1:0] prod_re, prod_im;
    logic signed [ACC_W-1:0]  term_re, term_im;

    assign xr = {{EXT_W{x_re_i[DATA_W-1]}}, x_re_i};
    assign xi = {{EXT_W{x_im_i[DATA_W-1]}}, x_im_i};
    assign yr = {{EXT_W{y_re_i[DATA_W-1]}}, y_re_i};
    assign yi = {{EXT_W{y_im_i[DATA_W-1]}}, y_im_i};

    // complex product, exact in PROD_W bits
    assign prod_re = xr * yr - xi * yi;
    assign prod_im = xr * yi + xi * yr;

    always_comb begin
        term_re = {{PAD_W{prod_re[PROD_W-1]}}, prod_re};
        term_im = {{PAD_W{prod_im[PROD_W-1]}}, prod_im};
        if (sub_i) begin
            term_re = -term_re;
            term_im = -term_im;
        end
    end

    // wide adder, wraps at ACC_W
    assign sum_re_o = add_re_i + term_re;
    assign sum_im_o = add_im_i + term_im;

    assign ovf_re_o = (add_re_i[ACC_W-1] == term_re[ACC_W-1]) &&
                      (sum_re_o[ACC_W-1] != add_re_i[ACC_W-1]);
    assign ovf_im_o = (add_im_i[ACC_W-1] == term_im[ACC_W-1]) &&
                      (sum_im_o[ACC_W-1] != add_im_i[ACC_W-1]);
endmodule

// File: rtl/cmac_maxsrch.sv
module cmac_maxsrch
    import cmac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 8,
    localparam int MAG_W = DATA_W + 1
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step_i,
    input  logic                   restart_i,
    input  logic [2*DATA_W-1:0]    a_re_i,
    input  logic [2*DATA_W-1:0]    a_im_i,
    output logic [MAG_W-1:0]       max_mag_o,
    output logic [IDX_W-1:0]       max_idx_o
);
    srch_state_e state_q, state_d;

    logic [MAG_W-1:0] best_q;
    logic [IDX_W-1:0] best_idx_q;
    logic [IDX_W-1:0] base_q;
    logic [MAG_W-1:0] mag0, mag1, cand_mag;
    logic             cand_sel;
    logic [IDX_W-1:0] base_eff;
    logic             take;

    function automatic logic [MAG_W-1:0] abs_ext(input logic [DATA_W-1:0] v);
        logic [MAG_W-1:0] e;
        e = {v[DATA_W-1], v};
        return e[MAG_W-1] ? (~e + 1'b1) : e;
    endfunction

    assign mag0 = abs_ext(a_re_i[DATA_W-1:0]) + abs_ext(a_im_i[DATA_W-1:0]);
    assign mag1 = abs_ext(a_re_i[2*DATA_W-1:DATA_W]) + abs_ext(a_im_i[2*DATA_W-1:DATA_W]);

    // element 0 wins a tie inside one cycle
    assign cand_sel = (mag1 > mag0);
    assign cand_mag = cand_sel ? mag1 : mag0;
    assign base_eff = restart_i ? '0 : base_q;

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            SRCH_EMPTY: begin
                if (step_i) begin
                    state_d = SRCH_LIVE;
                    take    = 1'b1;
                end
            end
            SRCH_LIVE: begin
                if (step_i) begin
                    take = restart_i || (cand_mag > best_q);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRCH_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_q     <= '0;
            best_idx_q <= '0;
            base_q     <= '0;
        end else if (step_i) begin
            base_q <= base_eff + IDX_W'(2);
            if (take) begin
                best_q     <= cand_mag;
                best_idx_q <= base_eff + IDX_W'(cand_sel);
            end
        end
    end

    assign max_mag_o = best_q;
    assign max_idx_o = best_idx_q;

    assert_max_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRCH_LIVE && !(step_i && restart_i)) |=> (best_q >= $past(best_q)));

    assert_max_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (best_q >= $past(mag0) && best_q >= $past(mag1)));

    assert_restart_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && restart_i) |=> (best_idx_q <= IDX_W'(1)));
endmodule

// File: rtl/cmac_dual_lane.sv
module cmac_dual_lane
    import cmac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40,
    parameter int ACC_N  = 4,
    parameter int IDX_W  = 8,
    localparam int SEL_W = (ACC_N > 1) ? $clog2(ACC_N) : 1,
    localparam int BF_W  = DATA_W + 2,
    localparam int MAG_W = DATA_W + 1
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid_i,
    input  logic [1:0]               mode_i,
    input  logic [SEL_W-1:0]         acc_sel_i,
    input  logic                     clear_i,
    input  logic [2*DATA_W-1:0]      a_re_i,
    input  logic [2*DATA_W-1:0]      a_im_i,
    input  logic [2*DATA_W-1:0]      b_re_i,
    input  logic [2*DATA_W-1:0]      b_im_i,
    output logic [ACC_N*ACC_W-1:0]   acc_re_o,
    output logic [ACC_N*ACC_W-1:0]   acc_im_o,
    output logic [ACC_N-1:0]         acc_ovf_o,
    output logic                     bf_valid_o,
    output logic [2*BF_W-1:0]        bf_re_o,
    output logic [2*BF_W-1:0]        bf_im_o,
    output logic [MAG_W-1:0]         max_mag_o,
    output logic [IDX_W-1:0]         max_idx_o
);
    localparam int LANES    = 2;
    localparam int ALIGN_SH = DATA_W - 1;
    localparam int OUT_SH   = DATA_W;
    localparam int XPAD_W   = ACC_W - DATA_W;

    cmac_op_e op;
    logic     do_mac, do_bfly, do_mag;

    assign op      = cmac_op_e'(mode_i);
    assign do_mac  = in_valid_i && (op == OP_MAC);
    assign do_bfly = in_valid_i && (op == OP_BFLY);
    assign do_mag  = in_valid_i && (op == OP_MAG);

    logic signed [ACC_W-1:0] acc_re_q [ACC_N];
    logic signed [ACC_W-1:0] acc_im_q [ACC_N];
    logic [ACC_N-1:0]        ovf_q;
    logic                    bf_valid_q;
    logic [2*BF_W-1:0]       bf_re_q, bf_im_q;

    logic signed [DATA_W-1:0] ar [LANES];
    logic signed [DATA_W-1:0] ai [LANES];
    logic signed [DATA_W-1:0] br [LANES];
    logic signed [DATA_W-1:0] bi [LANES];

    logic signed [ACC_W-1:0] sum_re [LANES];
    logic signed [ACC_W-1:0] sum_im [LANES];
    logic                    ov_re  [LANES];
    logic                    ov_im  [LANES];
    logic [SEL_W-1:0]        tgt    [LANES];

    logic signed [ACC_W-1:0] x_al_re, x_al_im;

    // butterfly first input aligned to the product scale
    assign x_al_re = {{XPAD_W{ar[0][DATA_W-1]}}, ar[0]} <<< ALIGN_SH;
    assign x_al_im = {{XPAD_W{ai[0][DATA_W-1]}}, ai[0]} <<< ALIGN_SH;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [DATA_W-1:0] mx_re, mx_im, my_re, my_im;
        logic signed [ACC_W-1:0]  ad_re, ad_im;
        logic                     sub;

        assign ar[k]  = a_re_i[k*DATA_W +: DATA_W];
        assign ai[k]  = a_im_i[k*DATA_W +: DATA_W];
        assign br[k]  = b_re_i[k*DATA_W +: DATA_W];
        assign bi[k]  = b_im_i[k*DATA_W +: DATA_W];
        assign tgt[k] = SEL_W'((int'(acc_sel_i) + k) % ACC_N);

        always_comb begin
            if (op == OP_BFLY) begin
                mx_re = ar[1];
                mx_im = ai[1];
                my_re = br[0];
                my_im = bi[0];
                ad_re = x_al_re;
                ad_im = x_al_im;
                sub   = (k == 1);
            end else begin
                mx_re = ar[k];
                mx_im = ai[k];
                my_re = br[k];
                my_im = bi[k];
                ad_re = clear_i ? '0 : acc_re_q[tgt[k]];
                ad_im = clear_i ? '0 : acc_im_q[tgt[k]];
                sub   = 1'b0;
            end
        end

        cmac_lane #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_lane (
            .x_re_i   (mx_re),
            .x_im_i   (mx_im),
            .y_re_i   (my_re),
            .y_im_i   (my_im),
            .add_re_i (ad_re),
            .add_im_i (ad_im),
            .sub_i    (sub),
            .sum_re_o (sum_re[k]),
            .sum_im_o (sum_im[k]),
            .ovf_re_o (ov_re[k]),
            .ovf_im_o (ov_im[k])
        );
    end

    // accumulator bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ACC_N; i++) begin
                acc_re_q[i] <= '0;
                acc_im_q[i] <= '0;
            end
            ovf_q <= '0;
        end else if (do_mac) begin
            for (int i = 0; i < ACC_N; i++) begin
                for (int k = 0; k < LANES; k++) begin
                    if (tgt[k] == SEL_W'(i)) begin
                        acc_re_q[i] <= sum_re[k];
                        acc_im_q[i] <= sum_im[k];
                        ovf_q[i]    <= (ovf_q[i] & ~clear_i) | ov_re[k] | ov_im[k];
                    end
                end
            end
        end
    end

    // butterfly result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bf_valid_q <= 1'b0;
            bf_re_q    <= '0;
            bf_im_q    <= '0;
        end else begin
            bf_valid_q <= do_bfly;
            if (do_bfly) begin
                for (int k = 0; k < LANES; k++) begin
                    bf_re_q[k*BF_W +: BF_W] <= sum_re[k][OUT_SH +: BF_W];
                    bf_im_q[k*BF_W +: BF_W] <= sum_im[k][OUT_SH +: BF_W];
                end
            end
        end
    end

    cmac_maxsrch #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_srch (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (do_mag),
        .restart_i (clear_i),
        .a_re_i    (a_re_i),
        .a_im_i    (a_im_i),
        .max_mag_o (max_mag_o),
        .max_idx_o (max_idx_o)
    );

    for (genvar i = 0; i < ACC_N; i++) begin : g_flat
        assign acc_re_o[i*ACC_W +: ACC_W] = acc_re_q[i];
        assign acc_im_o[i*ACC_W +: ACC_W] = acc_im_q[i];
    end

    assign acc_ovf_o  = ovf_q;
    assign bf_valid_o = bf_valid_q;
    assign bf_re_o    = bf_re_q;
    assign bf_im_o    = bf_im_q;

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_mac || do_bfly || do_mag) |=>
            ($stable(acc_re_o) && $stable(acc_im_o) && $stable(acc_ovf_o) &&
             $stable(max_mag_o) && $stable(max_idx_o) && !bf_valid_o));

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_mac && clear_i) |=> ((acc_ovf_o & $past(acc_ovf_o)) == $past(acc_ovf_o)));

    assert_bf_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        do_bfly |=> (bf_valid_o && $stable(acc_re_o) && $stable(acc_im_o)));

    assert_clear_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_mac && clear_i) |=> !acc_ovf_o[$past(acc_sel_i)]);
endmodule

// File: tb/sim_cmac_dual_lane.sv
module sim_cmac_dual_lane;
    localparam int CLK_P = 10;
    localparam int DW = 16;
    localparam int AW = 40;
    localparam int NA = 4;
    localparam int BW = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] mode = 2'd3;
    logic [1:0] sel = 2'd0;
    logic clear = 1'b0;
    logic [2*DW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic [NA*AW-1:0] acc_re, acc_im;
    logic [NA-1:0] acc_ovf;
    logic bf_valid;
    logic [2*BW-1:0] bf_re, bf_im;
    logic [16:0] max_mag;
    logic [7:0] max_idx;

    always #(CLK_P/2) clk = ~clk;

    cmac_dual_lane u0 (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .mode_i(mode),
        .acc_sel_i(sel), .clear_i(clear),
        .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im),
        .acc_re_o(acc_re), .acc_im_o(acc_im), .acc_ovf_o(acc_ovf),
        .bf_valid_o(bf_valid), .bf_re_o(bf_re), .bf_im_o(bf_im),
        .max_mag_o(max_mag), .max_idx_o(max_idx)
    );

    int n_chk = 0;
    int n_fail = 0;
    int unsigned seed = 32'h1234_5678;

    // operands for the next step
    int ar[2], ai[2], br[2], bi[2];

    // reference model state
    longint m_re[NA], m_im[NA];
    logic [NA-1:0] m_ovf;
    bit m_bfv;
    longint m_bf_re[2], m_bf_im[2];
    longint m_max;
    int m_idx, m_base;
    bit m_live;

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[30:15]));
    endfunction

    function automatic longint wrap40(input longint x);
        logic signed [39:0] b;
        b = x[39:0];
        return longint'(b);
    endfunction

    function automatic longint iabs(input longint x);
        return (x < 0) ? -x : x;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        for (int i = 0; i < NA; i++) begin
            logic signed [AW-1:0] vr, vi;
            vr = acc_re[i*AW +: AW];
            vi = acc_im[i*AW +: AW];
            chk(longint'(vr) == m_re[i], tag, $sformatf("acc%0d_re", i), longint'(vr), m_re[i]);
            chk(longint'(vi) == m_im[i], tag, $sformatf("acc%0d_im", i), longint'(vi), m_im[i]);
        end
        chk(acc_ovf == m_ovf, "R4", "ovf", longint'(acc_ovf), longint'(m_ovf));
        chk(bf_valid == m_bfv, "R5", "bf_valid", longint'(bf_valid), longint'(m_bfv));
        for (int k = 0; k < 2; k++) begin
            logic signed [BW-1:0] qr, qi;
            qr = bf_re[k*BW +: BW];
            qi = bf_im[k*BW +: BW];
            chk(longint'(qr) == m_bf_re[k], "R5", $sformatf("bf%0d_re", k), longint'(qr), m_bf_re[k]);
            chk(longint'(qi) == m_bf_im[k], "R5", $sformatf("bf%0d_im", k), longint'(qi), m_bf_im[k]);
        end
        chk(longint'(max_mag) == m_max, "R7", "max_mag", longint'(max_mag), m_max);
        chk(int'(max_idx) == m_idx, "R6", "max_idx", longint'(max_idx), longint'(m_idx));
    endtask

    task automatic model_update(input bit v, input int md, input int s, input bit clr);
        m_bfv = v && (md == 1);
        if (v && md == 0) begin
            for (int k = 0; k < 2; k++) begin
                int t;
                longint pr, pi, er, ei, wr, wi;
                t  = (s + k) % NA;
                pr = longint'(ar[k]) * br[k] - longint'(ai[k]) * bi[k];
                pi = longint'(ar[k]) * bi[k] + longint'(ai[k]) * br[k];
                er = (clr ? 0 : m_re[t]) + pr;
                ei = (clr ? 0 : m_im[t]) + pi;
                wr = wrap40(er);
                wi = wrap40(ei);
                m_ovf[t] = (clr ? 1'b0 : m_ovf[t]) | (wr != er) | (wi != ei);
                m_re[t] = wr;
                m_im[t] = wi;
            end
        end
        if (m_bfv) begin
            longint pr, pi;
            pr = longint'(ar[1]) * br[0] - longint'(ai[1]) * bi[0];
            pi = longint'(ar[1]) * bi[0] + longint'(ai[1]) * br[0];
            m_bf_re[0] = (longint'(ar[0]) * 32768 + pr) >>> 16;
            m_bf_im[0] = (longint'(ai[0]) * 32768 + pi) >>> 16;
            m_bf_re[1] = (longint'(ar[0]) * 32768 - pr) >>> 16;
            m_bf_im[1] = (longint'(ai[0]) * 32768 - pi) >>> 16;
        end
        if (v && md == 2) begin
            longint g0, g1, cm;
            int ci, b;
            g0 = iabs(ar[0]) + iabs(ai[0]);
            g1 = iabs(ar[1]) + iabs(ai[1]);
            ci = (g1 > g0) ? 1 : 0;
            cm = (g1 > g0) ? g1 : g0;
            b  = clr ? 0 : m_base;
            if (!m_live || clr || cm > m_max) begin
                m_max = cm;
                m_idx = (b + ci) % 256;
            end
            m_base = (b + 2) % 256;
            m_live = 1'b1;
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input bit v, input int md, input int s, input bit clr, input string tag);
        in_valid = v;
        mode     = md[1:0];
        sel      = s[1:0];
        clear    = clr;
        a_re = {ar[1][15:0], ar[0][15:0]};
        a_im = {ai[1][15:0], ai[0][15:0]};
        b_re = {br[1][15:0], br[0][15:0]};
        b_im = {bi[1][15:0], bi[0][15:0]};
        @(posedge clk);
        model_update(v, md, s, clr);
        #(CLK_P/5);
        compare(tag);
        @(negedge clk);
    endtask

    task automatic rand_ops();
        for (int k = 0; k < 2; k++) begin
            ar[k] = rnd16(); ai[k] = rnd16(); br[k] = rnd16(); bi[k] = rnd16();
        end
    endtask

    task automatic set_a(input int r0, input int i0, input int r1, input int i1);
        ar[0] = r0; ai[0] = i0; ar[1] = r1; ai[1] = i1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < NA; i++) begin m_re[i] = 0; m_im[i] = 0; end
        m_ovf = '0; m_bfv = 1'b0;
        for (int k = 0; k < 2; k++) begin
            m_bf_re[k] = 0; m_bf_im[k] = 0;
            ar[k] = 0; ai[k] = 0; br[k] = 0; bi[k] = 0;
        end
        m_max = 0; m_idx = 0; m_base = 0; m_live = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_P/5);
        compare("R1");
        @(negedge clk);

        // R3: load, then R2 accumulate into acc0/acc1
        rand_ops(); step(1, 0, 0, 1, "R3");
        for (int n = 0; n < 7; n++) begin rand_ops(); step(1, 0, 0, 0, "R2"); end
        // R3 / R2 with wrap of the target index (acc3 and acc0)
        rand_ops(); step(1, 0, 3, 1, "R3");
        for (int n = 0; n < 4; n++) begin rand_ops(); step(1, 0, 3, 0, "R2"); end
        rand_ops(); step(1, 0, 2, 1, "R3");
        rand_ops(); step(1, 0, 1, 0, "R2");

        // R9: invalid cycles and no-operation code
        for (int n = 0; n < 3; n++) begin rand_ops(); step(0, 0, 1, 1, "R9"); end
        for (int n = 0; n < 2; n++) begin rand_ops(); step(1, 3, 0, 1, "R9"); end

        // R5: butterfly, extreme and random operands
        set_a(32767, -32768, -32768, -32768);
        br[0] = -32768; bi[0] = 32767; br[1] = 5; bi[1] = 7;
        step(1, 1, 0, 0, "R5");
        set_a(-32768, 32767, 32767, 32767);
        br[0] = 32767; bi[0] = -32768;
        step(1, 1, 0, 1, "R5");
        for (int n = 0; n < 6; n++) begin rand_ops(); step(1, 1, 2, 0, "R5"); end
        rand_ops(); step(1, 3, 0, 0, "R9");

        // R8: first magnitude cycle after reset, tie inside the cycle
        set_a(100, -50, -75, 75); step(1, 2, 0, 0, "R8");
        // R7: tie with running max keeps older index
        set_a(10, 10, 150, 0); step(1, 2, 0, 0, "R7");
        // R7: larger element 1 replaces
        set_a(0, 1, -200, 1); step(1, 2, 0, 0, "R7");
        // R6: accumulate cycle does not disturb search
        rand_ops(); step(1, 0, 1, 0, "R6");
        set_a(-32768, -32768, 3, 3); step(1, 2, 0, 0, "R6");
        for (int n = 0; n < 5; n++) begin rand_ops(); step(1, 2, 0, 0, "R6"); end
        // R8: restart with smaller values
        set_a(1, 2, 3, -4); step(1, 2, 0, 1, "R8");
        set_a(0, 0, 7, 0); step(1, 2, 0, 0, "R7");
        for (int n = 0; n < 4; n++) begin rand_ops(); step(1, 2, 3, 0, "R6"); end

        // R4: drive acc0/acc1 past the 40-bit range with full-scale products
        set_a(-32768, -32768, -32768, -32768);
        br[0] = -32768; bi[0] = 32767; br[1] = -32768; bi[1] = 32767;
        step(1, 0, 0, 1, "R3");
        for (int n = 0; n < 300; n++) step(1, 0, 0, 0, "R4");
        rand_ops(); step(1, 2, 0, 0, "R4");
        rand_ops(); step(1, 1, 0, 0, "R4");
        rand_ops(); step(0, 0, 0, 1, "R4");
        // R3: clearing accumulate on acc0/acc1 drops their flags
        rand_ops(); step(1, 0, 0, 1, "R3");
        rand_ops(); step(1, 0, 0, 0, "R2");

        finish_run();
    end
endmodule